// File: doc/BRIEF.md
# CAN Transmit Enable Safety Controller

This block sits between the transmit data line of a CAN protocol controller and the enable of the bus driver. It decides, on every clock, whether the driver may pull the bus dominant. A low level on the transmit line asks for a dominant bit and a high level asks for a recessive bit. The block passes a dominant request through only when no protection condition is active.

Five conditions can force the bus recessive: standby mode, an over-long dominant request, a thermal fault, core supply undervoltage and I/O supply undervoltage. All time limits are parameters counted in clock cycles. Every input first passes through a synchronizer. The fault flags come from analog comparators elsewhere and are already digital.

After a fault, transmission does not resume as soon as the fault flag drops. The controller must first return the transmit line high. Core undervoltage also needs a fixed recovery interval first. A sticky code reports which fault last suppressed a dominant request.

Top module: `can_tx_guard`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied, `drive_dom_o` is 0, `bus_disengage_o` is 0 and `fault_code_o` is 0 at the following clock edge.
- R2: Each input passes through a synchronizer of `SYNC_STAGES` flops (default 2). With no fault active, `drive_dom_o` goes to 1 on the third rising edge after `txd_i` goes low and is still 0 after the second.
- R3: A high level on `txd_i` makes `drive_dom_o` 0 on the third rising edge after the change.
- R4: When the synchronized transmit line has been low for `TIMEOUT_CYC` consecutive cycles, `drive_dom_o` falls one edge later and stays 0 for as long as the line stays low. A return to high clears the timer, and the next low request drives again.
- R5: An active thermal flag forces `drive_dom_o` to 0. The block stays off after the flag drops and is released only once the transmit line has been seen high.
- R6: An active core undervoltage flag forces `drive_dom_o` to 0. After the flag drops, `RECOVER_CYC` cycles must pass, and then the transmit line must be seen high, before a dominant bit is driven again. A high level during the recovery interval does not release the block.
- R7: `bus_disengage_o` follows the synchronized I/O undervoltage flag. While it is set, `drive_dom_o` is 0. After the flag clears, driving stays off until the transmit line has been seen high.
- R8: With `stby_i` high, `drive_dom_o` is 0. Standby is not a fault and leaves `fault_code_o` unchanged.
- R9: When a dominant request is suppressed by a fault, `fault_code_o` takes the code of the highest-priority active fault. The order from highest is I/O undervoltage = 4, core undervoltage = 3, thermal = 2, time-out = 1. The code holds until the next dominant request that is let through, which sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| txd_i | input | 1 | Transmit data from the controller; 0 asks for dominant |
| stby_i | input | 1 | 1 selects standby, 0 normal operation |
| therm_flt_i | input | 1 | Over-temperature flag |
| core_uv_i | input | 1 | Core supply undervoltage flag |
| io_uv_i | input | 1 | I/O supply undervoltage flag |
| drive_dom_o | output | 1 | 1 commands the driver to pull the bus dominant |
| bus_disengage_o | output | 1 | 1 detaches the transmitter from the bus |
| fault_code_o | output | 3 | Sticky code of the fault that last suppressed a dominant request |

## Verification
The assertions work on the synchronized copies of the inputs. They assume each flag is a level that holds for at least one clock, so that every change reaches the sampled domain. The stimulus changes inputs only on falling clock edges and holds every level for several cycles. Low stretches of the transmit line stay shorter than the time-out, except where the time-out itself is being exercised, so that a suppression seen in another scenario has a single cause.

// File: rtl/can_txg_pkg.sv
package can_txg_pkg;
   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_TIMEOUT = 3'd1,
      FC_THERMAL = 3'd2,
      FC_CORE_UV = 3'd3,
      FC_IO_UV   = 3'd4
   } fault_code_e;

   localparam int unsigned SYNC_BITS = 5;
   localparam int unsigned IDX_TXD   = 0;
   localparam int unsigned IDX_STBY  = 1;
   localparam int unsigned IDX_THERM = 2;
   localparam int unsigned IDX_CUV   = 3;
   localparam int unsigned IDX_IOUV  = 4;
   // transmit line and mode rest high (recessive, standby); flags rest low
   localparam logic [SYNC_BITS-1:0] SYNC_IDLE = 5'b00011;
endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stage[0] <= RST_VAL;
      else        stage[0] <= d;
   end

   genvar g;
   generate
      for (g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) stage[g] <= RST_VAL;
            else        stage[g] <= stage[g-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
   parameter int unsigned LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txd_s,
   input  logic txd_fall,
   input  logic txd_rise,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                                     cnt <= '0;
      else if (txd_rise)                              cnt <= '0;
      else if (txd_fall)                              cnt <= CW'(1);
      else if (!txd_s && cnt != '0 && cnt != LIM_C)   cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIM_C);
endmodule

// File: rtl/txg_fault_hold.sv
module txg_fault_hold #(
   parameter int unsigned HOLD_CYC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   input  logic txd_hi,
   output logic blocked
);
   logic held;

   generate
      if (HOLD_CYC == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n)      held <= 1'b0;
            else if (flag)   held <= 1'b1;
            else if (txd_hi) held <= 1'b0;
         end
      end else begin : g_timed
         localparam int unsigned HW = $clog2(HOLD_CYC + 1);
         localparam logic [HW-1:0] HOLD_C = HW'(HOLD_CYC);
         logic [HW-1:0] gap;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held <= 1'b0;
               gap  <= '0;
            end else if (flag) begin
               held <= 1'b1;
               gap  <= '0;
            end else if (held) begin
               if (gap != HOLD_C) gap  <= gap + 1'b1;
               else if (txd_hi)   held <= 1'b0;
            end
         end
      end
   endgenerate

   assign blocked = flag | held;
endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard
   import can_txg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT_CYC = 64,
   parameter int unsigned RECOVER_CYC = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       txd_i,
   input  logic       stby_i,
   input  logic       therm_flt_i,
   input  logic       core_uv_i,
   input  logic       io_uv_i,
   output logic       drive_dom_o,
   output logic       bus_disengage_o,
   output logic [2:0] fault_code_o
);
   localparam int unsigned THERM_HOLD = 0;
   localparam int unsigned IO_HOLD    = 0;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("can_tx_guard: SYNC_STAGES must be at least 2");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("can_tx_guard: TIMEOUT_CYC must be at least 1");
      end
   endgenerate

   logic [SYNC_BITS-1:0] raw, synced;
   logic txd_s, stby_s, therm_s, core_uv_s, io_uv_s;
   logic txd_d, txd_fall, txd_rise;
   logic to_exp, th_blk, cuv_blk, iuv_blk, fault_any, gate_off;
   logic drive_q;
   fault_code_e code_q;

   assign raw[IDX_TXD]   = txd_i;
   assign raw[IDX_STBY]  = stby_i;
   assign raw[IDX_THERM] = therm_flt_i;
   assign raw[IDX_CUV]   = core_uv_i;
   assign raw[IDX_IOUV]  = io_uv_i;

   txg_sync #(.WIDTH(SYNC_BITS), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
   );

   assign txd_s     = synced[IDX_TXD];
   assign stby_s    = synced[IDX_STBY];
   assign therm_s   = synced[IDX_THERM];
   assign core_uv_s = synced[IDX_CUV];
   assign io_uv_s   = synced[IDX_IOUV];

   always_ff @(posedge clk) begin
      if (!rst_n) txd_d <= 1'b1;
      else        txd_d <= txd_s;
   end
   assign txd_fall = txd_d & ~txd_s;
   assign txd_rise = ~txd_d & txd_s;

   txg_dom_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .txd_s(txd_s),
      .txd_fall(txd_fall), .txd_rise(txd_rise), .expired(to_exp)
   );

   txg_fault_hold #(.HOLD_CYC(THERM_HOLD)) u_therm (
      .clk(clk), .rst_n(rst_n), .flag(therm_s), .txd_hi(txd_s), .blocked(th_blk)
   );
   txg_fault_hold #(.HOLD_CYC(RECOVER_CYC)) u_core_uv (
      .clk(clk), .rst_n(rst_n), .flag(core_uv_s), .txd_hi(txd_s), .blocked(cuv_blk)
   );
   txg_fault_hold #(.HOLD_CYC(IO_HOLD)) u_io_uv (
      .clk(clk), .rst_n(rst_n), .flag(io_uv_s), .txd_hi(txd_s), .blocked(iuv_blk)
   );

   assign fault_any = to_exp | th_blk | cuv_blk | iuv_blk;
   assign gate_off  = fault_any | stby_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         code_q  <= FC_NONE;
      end else begin
         drive_q <= ~txd_s & ~gate_off;
         if (!txd_s) begin
            if (iuv_blk)      code_q <= FC_IO_UV;
            else if (cuv_blk) code_q <= FC_CORE_UV;
            else if (th_blk)  code_q <= FC_THERMAL;
            else if (to_exp)  code_q <= FC_TIMEOUT;
            else if (!stby_s) code_q <= FC_NONE;
         end
      end
   end

   assign drive_dom_o     = drive_q;
   assign bus_disengage_o = io_uv_s;
   assign fault_code_o    = code_q;
endmodule

// File: rtl/txg_guard_chk.sv
module txg_guard_chk #(
   parameter int unsigned TIMEOUT_CYC = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       txd_s,
   input logic       stby_s,
   input logic       core_uv_s,
   input logic       io_uv_s,
   input logic       drive,
   input logic       disengage,
   input logic [2:0] code
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LIM_C = CW'(TIMEOUT_CYC);

   logic [CW-1:0] low_run;
   always_ff @(posedge clk) begin
      if (!rst_n || txd_s)     low_run <= '0;
      else if (low_run != LIM_C) low_run <= low_run + 1'b1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (drive == 1'b0 && code == 3'd0));

   p_recessive_on_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      txd_s |=> !drive);

   p_timeout_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (low_run == LIM_C) |=> !drive);

   p_core_uv_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_uv_s |=> !drive);

   p_io_uv_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_uv_s && disengage) |=> !drive);

   p_standby_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stby_s |=> !drive);

   p_code_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (code == 3'd0));

   p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      code <= 3'd4);
endmodule

bind can_tx_guard txg_guard_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .txd_s(txd_s), .stby_s(stby_s),
   .core_uv_s(core_uv_s), .io_uv_s(io_uv_s), .drive(drive_dom_o),
   .disengage(bus_disengage_o), .code(fault_code_o)
);

// File: tb/sim_can_tx_guard.sv
`timescale 1ns/1ps
module sim_can_tx_guard;
   localparam int TO = 64;
   localparam int RC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txd = 1'b1, stby = 1'b0, therm = 1'b0, cuv = 1'b0, iuv = 1'b0;
   logic drive, diseng;
   logic [2:0] code;

   always #2 clk = ~clk;

   can_tx_guard #(.SYNC_STAGES(2), .TIMEOUT_CYC(TO), .RECOVER_CYC(RC)) u0 (
      .clk(clk), .rst_n(rst_n), .txd_i(txd), .stby_i(stby), .therm_flt_i(therm),
      .core_uv_i(cuv), .io_uv_i(iuv), .drive_dom_o(drive),
      .bus_disengage_o(diseng), .fault_code_o(code)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // behavioural reference: delay line for inputs, run-length, hold flags
   bit [4:0] m_s1, m_s2;
   int m_low, m_gap, m_code;
   bit m_th_h, m_cu_h, m_io_h, m_drive;

   always @(posedge clk) begin
      bit t, st, th, cu, io, thb, cub, iob, fault;
      if (!rst_n) begin
         m_s1 = 5'b00011; m_s2 = 5'b00011;
         m_low = 0; m_gap = 0; m_code = 0;
         m_th_h = 0; m_cu_h = 0; m_io_h = 0; m_drive = 0;
      end else begin
         t = m_s2[0]; st = m_s2[1]; th = m_s2[2]; cu = m_s2[3]; io = m_s2[4];
         thb = th | m_th_h; cub = cu | m_cu_h; iob = io | m_io_h;
         fault = thb | cub | iob | (m_low >= TO);
         m_drive = !t && !fault && !st;
         if (!t) begin
            if (iob)              m_code = 4;
            else if (cub)         m_code = 3;
            else if (thb)         m_code = 2;
            else if (m_low >= TO) m_code = 1;
            else if (!st)         m_code = 0;
         end
         m_low = t ? 0 : ((m_low < TO) ? m_low + 1 : TO);
         if (th) m_th_h = 1; else if (t) m_th_h = 0;
         if (io) m_io_h = 1; else if (t) m_io_h = 0;
         if (cu) begin m_cu_h = 1; m_gap = 0; end
         else if (m_cu_h) begin
            if (m_gap < RC) m_gap++;
            else if (t) m_cu_h = 0;
         end
         m_s2 = m_s1;
         m_s1 = {iuv, cuv, therm, stby, txd};
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(drive === m_drive, "R3 drive vs model", int'(drive), int'(m_drive));
         chk(diseng === m_s2[4], "R7 disengage vs model", int'(diseng), int'(m_s2[4]));
         chk(int'(code) == m_code, "R9 code vs model", int'(code), m_code);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(4);
      chk(drive == 0, "R1 reset drive", int'(drive), 0);
      chk(code == 0, "R1 reset code", int'(code), 0);
      chk(diseng == 0, "R1 reset disengage", int'(diseng), 0);
      rst_n = 1'b1;
      step(3);

      // R2 latency and R3 release
      txd = 0; step(2);
      chk(drive == 0, "R2 not yet", int'(drive), 0);
      step(1);
      chk(drive == 1, "R2 dominant", int'(drive), 1);
      step(5); txd = 1; step(2);
      chk(drive == 1, "R3 still dominant", int'(drive), 1);
      step(1);
      chk(drive == 0, "R3 recessive", int'(drive), 0);

      // R4 time-out
      step(5); txd = 0; step(TO + 2);
      chk(drive == 1, "R4 before limit", int'(drive), 1);
      step(1);
      chk(drive == 0, "R4 cut", int'(drive), 0);
      chk(code == 1, "R9 timeout code", int'(code), 1);
      step(20);
      chk(drive == 0, "R4 stays cut", int'(drive), 0);
      txd = 1; step(5); txd = 0; step(3);
      chk(drive == 1, "R4 re-armed", int'(drive), 1);
      chk(code == 0, "R9 cleared", int'(code), 0);

      // R5 thermal
      therm = 1; step(4);
      chk(drive == 0, "R5 thermal off", int'(drive), 0);
      chk(code == 2, "R9 thermal code", int'(code), 2);
      therm = 0; step(10);
      chk(drive == 0, "R5 held until high", int'(drive), 0);
      txd = 1; step(4); txd = 0; step(3);
      chk(drive == 1, "R5 released", int'(drive), 1);
      txd = 1; step(4);

      // R6 core undervoltage
      txd = 0; step(3);
      cuv = 1; step(3);
      chk(drive == 0, "R6 core uv off", int'(drive), 0);
      chk(code == 3, "R9 core uv code", int'(code), 3);
      cuv = 0; txd = 1; step(3); txd = 0; step(8);
      chk(drive == 0, "R6 early high ignored", int'(drive), 0);
      txd = 1; step(RC + 5); txd = 0; step(3);
      chk(drive == 1, "R6 recovered", int'(drive), 1);
      chk(code == 0, "R9 cleared after core uv", int'(code), 0);
      txd = 1; step(4);

      // R7 I/O undervoltage and R9 priority
      txd = 0; step(3);
      iuv = 1; cuv = 1; step(2);
      chk(diseng == 1, "R7 disengage", int'(diseng), 1);
      step(1);
      chk(drive == 0, "R7 io uv off", int'(drive), 0);
      chk(code == 4, "R9 priority io over core", int'(code), 4);
      cuv = 0; step(5);
      chk(code == 4, "R9 io code holds", int'(code), 4);
      iuv = 0; step(3);
      chk(diseng == 0, "R7 reengage", int'(diseng), 0);
      chk(drive == 0, "R7 held until high", int'(drive), 0);
      txd = 1; step(RC + 5); txd = 0; step(3);
      chk(drive == 1, "R7 released", int'(drive), 1);
      txd = 1; step(4);

      // R8 standby
      stby = 1; txd = 0; step(6);
      chk(drive == 0, "R8 standby off", int'(drive), 0);
      chk(code == 0, "R8 standby no code", int'(code), 0);
      stby = 0; step(3);
      chk(drive == 1, "R8 normal again", int'(drive), 1);
      txd = 1; step(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule